// File: doc/BRIEF.md
# Freezable Event Counter Bank

A bank of performance counters on a plain 32-bit register bus. Counter 0 is a 64-bit cycle counter that advances on every clock. Counters 1 and up are 32 bits wide. Each one counts pulses from one line of a wide event input, and a 7-bit code in its control register picks that line. Software can stop counting in two ways: a freeze bit in each counter's control register, or a single freeze-all bit in the global control register.

Each counter has its own condition-enable bit, and the global register has an interrupt enable and a freeze-on-condition enable. When all three are set and an increment moves a counter's top bit from 0 to 1, the hardware sets the freeze-all bit. Every counter then stops, and a level interrupt is raised. Software collects the counts, clears the top bit of the counter that tripped, and clears freeze-all to count again.

Top module: `pmon_bank`

## Requirements
- R1: After reset, every register reads zero and irq is low. Counter 0 starts counting up from zero once reset is released.
- R2: The global control word at byte address 0x40 holds three bits: freeze-all at bit 31, interrupt enable at bit 30 and freeze-on-condition enable at bit 29. Its other bits read zero.
- R3: Counter n has a control word at 0x50+0x10·n, with freeze at bit 31, condition enable at bit 26 and the event code at bits 22:16. Its other bits read zero. The word at 0x54+0x10·n reads zero and ignores writes.
- R4: The low word of counter 0 is at 0x58 and the high word is at 0x5C. While running, counter 0 adds one every clock as a single 64-bit value, so the carry passes from the low word into the high word.
- R5: The count of counter n (n ≥ 1) is at 0x58+0x10·n. It adds one in each clock in which ev_in[code−1] is high. With code 0 it holds.
- R6: A counter advances only while its own freeze bit and the global freeze-all bit are both clear. Setting either bit stops it. Clearing both bits lets it resume from the value it held.
- R7: A write to a count word loads the written value, so writing zero clears the counter. If an increment falls in the same clock as the write, the write wins.
- R8: An increment that changes a counter's top bit from 0 to 1 sets freeze-all from the next clock on, and the increment itself still lands. This happens only if the counter's condition enable, the interrupt enable and the freeze-on-condition enable are all set.
- R9: irq is high only when all of these hold:
  - freeze-all is set;
  - both global enables are set;
  - some counter has both its condition enable and its top bit set.

  Clearing freeze-all, or the top bit of that counter, drops irq.
- R10: If a hardware trip and a software write to the global word fall in the same clock, freeze-all ends up set whatever the write carries in bit 31. The other two bits take the written values.
- R11: Writes to unmapped or misaligned addresses change nothing, and reads from them return zero. Examples are 0x44, 0x42, and a counter's high-word slot for n ≥ 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | AW (8) | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_in | input | 2^SELW−1 (127) | Event lines; code k selects line k−1 |
| irq | output | 1 | Overflow interrupt, level high |

## Verification
A hardware self-freeze can land in the same clock as a software write to the global control word. The bench provokes this by preloading counter 1 with 0x7FFFFFFF and enabling the trip. It then pulses the selected event line in the same clock as a global write that clears freeze-all and freeze-on-condition. The result is judged by reading back 0xC0000000 and a count of 0x80000000. A second collision, an event pulse against a count write, is judged by the loaded value reading back without the extra count.

// File: rtl/pmon_bank.sv
module pmon_bank #(
  parameter int NCNT = 11,
  parameter int SELW = 7,
  parameter int AW = 8,
  localparam int NEV = (1 << SELW) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NEV-1:0]  ev_in,
  output logic            irq
);
  localparam int IW = AW - 4;
  localparam logic [AW-1:0] GCTL = AW'('h40);
  localparam logic [AW-1:0] BANK = AW'('h50);
  localparam logic [IW-1:0] NC = IW'(NCNT);

  logic gfrz, irq_en, cfe;
  logic [NCNT-1:0] lfrz_v, ce_v, msb_v, trip_v;
  logic [NCNT-1:0][31:0] ctla_q, cnt_q;
  logic [31:0] cyc_hi;
  logic [AW-1:0] off;
  logic [IW-1:0] cidx;
  logic [1:0] sub;
  logic aligned, ctl_hit, bank_hit, trip;

  assign aligned  = bus_addr[1:0] == 2'b00;
  assign off      = bus_addr - BANK;
  assign cidx     = off[AW-1:4];
  assign sub      = off[3:2];
  assign ctl_hit  = aligned && bus_addr == GCTL;
  assign bank_hit = aligned && bus_addr >= BANK && cidx < NC;
  assign trip     = irq_en && cfe && |trip_v;
  assign irq      = gfrz && irq_en && cfe && |(ce_v & msb_v);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {gfrz, irq_en, cfe} <= '0;
    else begin
      if (bus_wr && ctl_hit) {gfrz, irq_en, cfe} <= bus_wdata[31:29];
      if (trip) gfrz <= 1'b1;
    end

  for (genvar n = 0; n < NCNT; n++) begin : g_cnt
    logic frz_q, ce_q, run, wr_a, wr_c;
    logic [SELW-1:0] sel_q;

    assign run  = !frz_q && !gfrz;
    assign wr_a = bus_wr && bank_hit && cidx == IW'(n) && sub == 2'd0;
    assign wr_c = bus_wr && bank_hit && cidx == IW'(n) && sub == 2'd2;
    assign lfrz_v[n] = frz_q;
    assign ce_v[n]   = ce_q;
    assign ctla_q[n] = {frz_q, 4'b0, ce_q, 3'b0, 7'(sel_q), 16'b0};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        frz_q <= 1'b0;
        ce_q  <= 1'b0;
        sel_q <= '0;
      end else if (wr_a) begin
        frz_q <= bus_wdata[31];
        ce_q  <= bus_wdata[26];
        sel_q <= bus_wdata[16 +: SELW];
      end

    if (n == 0) begin : g_cyc
      logic [31:0] lo_q, hi_q;
      logic [63:0] cur;
      logic wr_h;
      assign cur  = {hi_q, lo_q};
      assign wr_h = bus_wr && bank_hit && cidx == IW'(n) && sub == 2'd3;
      assign trip_v[n] = run && ce_q && !wr_c && !wr_h && cur == {1'b0, {63{1'b1}}};
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) {hi_q, lo_q} <= '0;
        else if (wr_c || wr_h) begin
          if (wr_c) lo_q <= bus_wdata;
          if (wr_h) hi_q <= bus_wdata;
        end else if (run) {hi_q, lo_q} <= cur + 64'd1;
      assign cnt_q[n] = lo_q;
      assign cyc_hi   = hi_q;
      assign msb_v[n] = hi_q[31];
    end else begin : g_ev
      logic [31:0] c_q;
      logic hit;
      assign hit = run && sel_q != '0 && ev_in[sel_q - SELW'(1)];
      assign trip_v[n] = hit && ce_q && !wr_c && c_q == 32'h7FFF_FFFF;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) c_q <= '0;
        else if (wr_c) c_q <= bus_wdata;
        else if (hit) c_q <= c_q + 32'd1;
      assign cnt_q[n] = c_q;
      assign msb_v[n] = c_q[31];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (ctl_hit) bus_rdata = {gfrz, irq_en, cfe, 29'b0};
    else if (bank_hit)
      case (sub)
        2'd0: bus_rdata = ctla_q[cidx];
        2'd2: bus_rdata = cnt_q[cidx];
        2'd3: if (cidx == '0) bus_rdata = cyc_hi;
        default: ;
      endcase
  end
endmodule

module pmon_bank_chk #(
  parameter int NCNT = 11
) (
  input logic clk,
  input logic rst_n,
  input logic bus_wr,
  input logic irq,
  input logic gfrz,
  input logic irq_en,
  input logic cfe,
  input logic lfrz0,
  input logic ce1,
  input logic msb1,
  input logic [31:0] cnt0,
  input logic [31:0] cnt1,
  input logic [NCNT-1:0][31:0] cnts
);
  // R6
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gfrz && !bus_wr) |=> $stable(cnts));

  // R8
  freeze_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gfrz && !bus_wr) |=> gfrz);

  // R4
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gfrz && !lfrz0 && !bus_wr) |=> cnt0 == $past(cnt0) + 32'd1);

  // R5
  event_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (cnt1 - $past(cnt1)) <= 32'd1);

  // R9
  trip_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(msb1) && ce1 && irq_en && cfe && !$past(bus_wr)) |-> irq);
endmodule

bind pmon_bank pmon_bank_chk #(.NCNT(NCNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .irq(irq), .gfrz(gfrz),
  .irq_en(irq_en), .cfe(cfe), .lfrz0(lfrz_v[0]), .ce1(ce_v[1]),
  .msb1(msb_v[1]), .cnt0(cnt_q[0]), .cnt1(cnt_q[1]), .cnts(cnt_q)
);

// File: tb/pmon_bank_test.sv
`timescale 1ns/100ps
module pmon_bank_test;
  localparam int NEV = 127;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, v, w;
  logic [NEV-1:0] ev_in = '0;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pmon_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_in(ev_in), .irq(irq)
  );

  typedef struct packed {
    logic [7:0] req;
    logic [7:0] a;
    logic [31:0] d;
    logic [31:0] e;
  } row_t;

  localparam row_t TBL [10] = '{
    '{8'd2,  8'h40, 32'hFFFF_FFFF, 32'hE000_0000},  // R2
    '{8'd3,  8'h50, 32'hFFFF_FFFF, 32'h847F_0000},  // R3
    '{8'd3,  8'h54, 32'hFFFF_FFFF, 32'h0000_0000},  // R3
    '{8'd3,  8'hF0, 32'h8404_0000, 32'h8404_0000},  // R3
    '{8'd4,  8'h5C, 32'hA5A5_A5A5, 32'hA5A5_A5A5},  // R4
    '{8'd7,  8'h68, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R7
    '{8'd7,  8'hF8, 32'h1234_5678, 32'h1234_5678},  // R7
    '{8'd11, 8'h6C, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    '{8'd11, 8'h44, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    '{8'd11, 8'h62, 32'h0000_FFFF, 32'h0000_0000}   // R11
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] r);
    bus_addr = a;
    #0.1;
    r = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 10; i++) begin
      wr(TBL[i].a, TBL[i].d);
      rd(TBL[i].a, v);
      chk($sformatf("R%0d table row %0d", TBL[i].req, i), v, TBL[i].e);
    end
    step(1);
    do_reset();

    rd(8'h40, v); chk("R1 global word", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h68, v); chk("R1 counter1", v, 32'h0);
    rd(8'h60, v); chk("R1 control1", v, 32'h0);
    rd(8'h58, v); chk("R1 cycle low", v, 32'h0);
    step(5);
    rd(8'h58, v); chk("R4 cycle after 5", v, 32'd5);

    wr(8'h40, 32'h8000_0000);
    rd(8'h58, v); chk("R6 freeze-all lands", v, 32'd6);
    step(3);
    rd(8'h58, v); chk("R6 frozen hold", v, 32'd6);

    wr(8'h58, 32'hFFFF_FFFE);
    wr(8'h5C, 32'h0000_0001);
    wr(8'h40, 32'h0);
    step(3);
    rd(8'h58, v); chk("R4 carry low", v, 32'd1);
    rd(8'h5C, v); chk("R4 carry high", v, 32'd2);

    wr(8'h60, 32'h0005_0000);
    ev_in = NEV'(32'h11); step(3);
    ev_in = NEV'(32'h01); step(2);
    ev_in = NEV'(32'h10); step(1);
    ev_in = '0;
    rd(8'h68, v); chk("R5 code 5 pattern", v, 32'd4);

    wr(8'hF0, 32'h007F_0000);
    ev_in = '1; step(4); ev_in = '0;
    rd(8'h68, v); chk("R5 counter1 all lines", v, 32'd8);
    rd(8'h78, v); chk("R5 code 0 holds", v, 32'd0);
    rd(8'hF8, v); chk("R5 code 127", v, 32'd4);

    wr(8'h60, 32'h8005_0000);
    ev_in = '1; step(3); ev_in = '0;
    rd(8'h68, v); chk("R6 local freeze", v, 32'd8);
    rd(8'hF8, v); chk("R6 neighbour runs", v, 32'd7);
    wr(8'h60, 32'h0005_0000);
    ev_in = '1; step(2); ev_in = '0;
    rd(8'h68, v); chk("R6 resume", v, 32'd10);

    ev_in = NEV'(32'h10);
    wr(8'h68, 32'h100);
    ev_in = '0;
    rd(8'h68, v); chk("R7 write beats increment", v, 32'h100);
    wr(8'h68, 32'h0);
    rd(8'h68, v); chk("R7 write zero clears", v, 32'h0);

    wr(8'h68, 32'h7FFF_FFFE);
    wr(8'h60, 32'h0405_0000);
    wr(8'h40, 32'h6000_0000);
    ev_in = NEV'(32'h10); step(2); ev_in = '0;
    rd(8'h68, v); chk("R8 tripping count lands", v, 32'h8000_0000);
    rd(8'h40, v); chk("R8 self freeze", v, 32'hE000_0000);
    chk("R9 irq raised", {31'b0, irq}, 32'h1);
    rd(8'h58, v); step(2); rd(8'h58, w);
    chk("R6 cycle frozen after trip", w, v);

    wr(8'h40, 32'h6000_0000);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    rd(8'h40, v); chk("R9 global after clear", v, 32'h6000_0000);
    wr(8'h68, 32'h0);

    wr(8'h60, 32'h0005_0000);
    wr(8'h68, 32'h7FFF_FFFF);
    ev_in = NEV'(32'h10); step(1); ev_in = '0;
    rd(8'h68, v); chk("R8 no ce count", v, 32'h8000_0000);
    rd(8'h40, v); chk("R8 no ce no freeze", v, 32'h6000_0000);
    chk("R9 no ce no irq", {31'b0, irq}, 32'h0);

    wr(8'h60, 32'h0405_0000);
    wr(8'h68, 32'h7FFF_FFFF);
    ev_in = NEV'(32'h10);
    wr(8'h40, 32'h4000_0000);
    ev_in = '0;
    rd(8'h40, v); chk("R10 trip beats write", v, 32'hC000_0000);
    rd(8'h68, v); chk("R10 count", v, 32'h8000_0000);

    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h40, v); chk("R11 unmapped write", v, 32'hC000_0000);
    wr(8'h42, 32'h0);
    rd(8'h40, v); chk("R11 misaligned write", v, 32'hC000_0000);
    wr(8'h6C, 32'hFFFF_FFFF);
    rd(8'h68, v); chk("R11 high slot n1", v, 32'h8000_0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule